// File: doc/BRIEF.md
# Interrupt Summary and Mask Registers

This block gathers nineteen level-sensitive interrupt request lines and combines them into one interrupt output for the processor. It sits on a byte-wide I/O bus and occupies three consecutive byte addresses starting at a base address (0x804 by default).

Each address serves as two registers. A read returns the live state of that byte's request lines. The mask does not affect the value read. A write loads the matching byte of a mask register, and software cannot read the mask back. A mask bit of 1 disables its source. The processor output goes high, one clock after the condition appears, whenever any enabled request is high. It stays high for as long as that request stays high.

After reset every source is masked. Software clears mask bits to enable the sources it services. When it handles an interrupt, it reads the three bytes to find which lines are active.

Top module: `irq_summary_mask`

## Requirements
- R1: While reset is asserted and after it is released, every mask bit is 1. With no write since reset, `irq_out` stays low even when every request line is high.
- R2: The three registers sit at BASE, BASE+1 and BASE+2. `bus_rdata` is 0 unless `bus_cs` and `bus_rd` are both high and `bus_addr` is one of those three addresses.
- R3: A read is combinational and completes in the same cycle. It returns the current request lines of that byte, whatever the mask holds.
- R4: Bits 7 to 3 of the register at BASE+2 have no source behind them and always read as 0.
- R5: A write with `bus_cs` and `bus_wr` high to one of the three addresses replaces that whole mask byte at the clock edge. The other mask bytes do not change. A write to any other address, or with `bus_cs` low, leaves the mask unchanged.
- R6: `irq_out` is a register. After each clock edge it equals the OR, over all sources, of request AND NOT mask, taken from the values just before that edge. A masked source never raises it.
- R7: `irq_out` stays high on every cycle while an enabled request stays high. It falls one cycle after the last enabled request drops or is masked.
- R8: Source n is `irq_req[n]`. It appears at bit n mod 8 of register n div 8, and its mask bit sits at the same place. The sources are assigned as follows:
  - Register 0: bits 0-3 are the A pins of slots 0-3, bit 4 is the bridge cascade, bit 5 is the storage controller, bit 6 is USB and bit 7 is the B pin of slot 0.
  - Register 1: bits 0-2 are the B pins of slots 1-3, bits 3-6 are the C pins of slots 0-3 and bit 7 is the D pin of slot 0.
  - Register 2: bits 0-2 are the D pins of slots 1-3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | I/O byte address |
| bus_wdata | input | 8 | Write data, one mask byte |
| bus_rdata | output | 8 | Read data: raw request byte, or 0 |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| irq_req | input | NUM_SRC (19) | Level request lines, indexed as in R8 |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is a mask byte changing in the same cycle that its request is already high. The output must show the old mask for exactly one more cycle and then follow the new one. The stimulus reaches this case in two ways. Directed sequences first unmask a single line, hold its request, then remask it or write to neighbouring and out-of-range addresses. A long random phase then issues writes, reads and request changes in the same cycles, with chip-select dropped at random. A reference model tracks mask bytes written only through the bus, so the mask that cannot be read back is still checked through `irq_out` on every clock.

// File: rtl/irqsum_pkg.sv
`timescale 1ns/1ps
package irqsum_pkg;
  localparam int BYTE_W = 8;

  // number of byte registers needed to hold n_src request lines
  function automatic int regs_needed(input int n_src);
    return (n_src + BYTE_W - 1) / BYTE_W;
  endfunction

  // number of live bits in register `lane`
  function automatic int lane_width(input int n_src, input int lane);
    int rem;
    rem = n_src - lane * BYTE_W;
    if (rem >= BYTE_W) return BYTE_W;
    if (rem < 0) return 0;
    return rem;
  endfunction
endpackage

// File: rtl/irqsum_decode.sv
`timescale 1ns/1ps
module irqsum_decode #(
  parameter int          ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h804,
  parameter int          NUM_REGS  = 3,
  parameter int          SEL_W     = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  output logic                in_range,
  output logic [SEL_W-1:0]    sel,
  output logic                rd_strobe,
  output logic [NUM_REGS-1:0] wr_lane
);
  logic [ADDR_W:0] offset;

  always_comb begin
    offset   = {1'b0, addr} - (ADDR_W+1)'(BASE_ADDR);
    in_range = ({1'b0, addr} >= (ADDR_W+1)'(BASE_ADDR)) &&
               (offset < (ADDR_W+1)'(NUM_REGS));
    sel      = offset[SEL_W-1:0];
  end

  assign rd_strobe = cs & rd & in_range;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    assign wr_lane[g] = cs & wr & in_range & (sel == SEL_W'(g));
  end
endmodule

// File: rtl/irqsum_mask_bank.sv
`timescale 1ns/1ps
module irqsum_mask_bank
  import irqsum_pkg::*;
#(
  parameter int NUM_SRC  = 19,
  parameter int NUM_REGS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] wr_lane,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [NUM_SRC-1:0]  mask_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam int LW = lane_width(NUM_SRC, g);
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '1;
      else if (wr_lane[g]) lane_q <= wdata[LW-1:0];
    end

    assign mask_q[g*BYTE_W +: LW] = lane_q;
  end
endmodule

// File: rtl/irqsum_readmux.sv
`timescale 1ns/1ps
module irqsum_readmux
  import irqsum_pkg::*;
#(
  parameter int NUM_SRC  = 19,
  parameter int NUM_REGS = 3,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [SEL_W-1:0]   sel,
  input  logic               rd_strobe,
  output logic [BYTE_W-1:0]  rdata
);
  localparam int PAD_W = NUM_REGS * BYTE_W;
  logic [PAD_W-1:0] raw_pad;

  assign raw_pad = PAD_W'(irq_req);

  always_comb begin
    rdata = '0;
    if (rd_strobe) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (sel == SEL_W'(k)) rdata = raw_pad[k*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/irqsum_combine.sv
`timescale 1ns/1ps
module irqsum_combine #(
  parameter int NUM_SRC = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic               pend_any,
  output logic               irq_out
);
  function automatic logic any_enabled(input logic [NUM_SRC-1:0] req,
                                       input logic [NUM_SRC-1:0] msk);
    return |(req & ~msk);
  endfunction

  assign pend_any = any_enabled(irq_req, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pend_any;
  end
endmodule

// File: rtl/irq_summary_mask.sv
`timescale 1ns/1ps
module irq_summary_mask
  import irqsum_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h804,
  parameter int          NUM_SRC   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic              irq_out
);
  localparam int NUM_REGS = regs_needed(NUM_SRC);
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                in_range;
  logic [SEL_W-1:0]    sel;
  logic                rd_strobe;
  logic [NUM_REGS-1:0] wr_lane;
  logic [NUM_SRC-1:0]  mask_q;
  logic                any_wr;
  logic                pend_any;

  irqsum_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) u_decode (
    .addr(bus_addr), .cs(bus_cs), .rd(bus_rd), .wr(bus_wr),
    .in_range(in_range), .sel(sel), .rd_strobe(rd_strobe), .wr_lane(wr_lane)
  );

  irqsum_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_REGS(NUM_REGS)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .wdata(bus_wdata), .mask_q(mask_q)
  );

  irqsum_readmux #(.NUM_SRC(NUM_SRC), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_rmux (
    .irq_req(irq_req), .sel(sel), .rd_strobe(rd_strobe), .rdata(bus_rdata)
  );

  irqsum_combine #(.NUM_SRC(NUM_SRC)) u_comb (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_q(mask_q),
    .pend_any(pend_any), .irq_out(irq_out)
  );

  assign any_wr = |wr_lane;
endmodule

// File: rtl/irqsum_checker.sv
`timescale 1ns/1ps
module irqsum_checker
  import irqsum_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned BASE_ADDR = 'h804,
  parameter int          NUM_SRC   = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_cs,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [7:0]         bus_rdata,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               any_wr
);
  localparam int NUM_REGS = regs_needed(NUM_SRC);
  localparam int TOP_W    = lane_width(NUM_SRC, NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(BASE_ADDR + NUM_REGS - 1);

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_rd) |-> bus_rdata == 8'h00);                      // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && bus_addr == TOP_ADDR) |-> (bus_rdata >> TOP_W) == 8'h00); // R4
  AST_MASK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q));                                      // R1
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(mask_q));                                     // R5
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_out);                                          // R6
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|irq_req));                                     // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_req & ~mask_q)) |=> irq_out);                              // R7
endmodule

bind irq_summary_mask irqsum_checker #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_req(irq_req),
  .irq_out(irq_out), .mask_q(mask_q), .any_wr(any_wr)
);

// File: tb/irq_summary_mask_test.sv
`timescale 1ns/1ps
module irq_summary_mask_test;
  localparam int BASE = 'h804;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [18:0] irq_req = '0;
  logic        irq_out;

  int checks = 0, fails = 0;
  bit started = 0, finished = 0;

  // reference model state
  int mmask [3] = '{'hff, 'hff, 'h07};
  bit exp_irq = 0;

  always #4 clk = ~clk;

  irq_summary_mask uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .irq_req(irq_req), .irq_out(irq_out)
  );

  function automatic int lane_bits(input int idx);
    return (idx == 2) ? 'h07 : 'hff;
  endfunction

  function automatic bit model_pending();
    for (int i = 0; i < 19; i++)
      if (irq_req[i] && ((mmask[i / 8] >> (i % 8)) & 1) == 0) return 1;
    return 0;
  endfunction

  function automatic int model_read();
    int idx;
    if (!(bus_cs && bus_rd)) return 0;
    idx = int'(bus_addr) - BASE;
    if (idx < 0 || idx > 2) return 0;
    return int'((32'(irq_req) >> (8 * idx)) & 32'hff);
  endfunction

  always @(posedge clk) begin
    int idx;
    if (!rst_n) begin
      mmask   <= '{'hff, 'hff, 'h07};
      exp_irq <= 0;
    end else begin
      exp_irq <= model_pending();
      idx = int'(bus_addr) - BASE;
      if (bus_cs && bus_wr && idx >= 0 && idx <= 2)
        mmask[idx] <= int'(bus_wdata) & lane_bits(idx);
    end
    started <= 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(bus_rdata == 8'(model_read()), "R3 read data", int'(bus_rdata), model_read());
      chk(irq_out == exp_irq, "R6 irq_out", int'(irq_out), int'(exp_irq));
    end
  end

  task automatic drive(input int a, input int d, input bit c, input bit r, input bit w);
    @(posedge clk); #2;
    bus_addr = 12'(a); bus_wdata = 8'(d); bus_cs = c; bus_rd = r; bus_wr = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    irq_req = '1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    chk(irq_out == 0, "R1 masked after reset", int'(irq_out), 0);

    drive('h804, 0, 1, 1, 0); @(negedge clk);
    chk(bus_rdata == 8'hff, "R3 raw read ignores mask", int'(bus_rdata), 'hff);
    drive('h806, 0, 1, 1, 0); @(negedge clk);
    chk(bus_rdata == 8'h07, "R4 reserved bits zero", int'(bus_rdata), 'h07);
    drive('h803, 0, 1, 1, 0); @(negedge clk);
    chk(bus_rdata == 8'h00, "R2 below range", int'(bus_rdata), 0);
    drive('h807, 0, 1, 1, 0); @(negedge clk);
    chk(bus_rdata == 8'h00, "R2 above range", int'(bus_rdata), 0);
    drive('h805, 0, 0, 1, 0); @(negedge clk);
    chk(bus_rdata == 8'h00, "R2 no chip select", int'(bus_rdata), 0);

    // unmask source 8 (register 1 bit 0, slot 1 B pin)
    irq_req = '0;
    drive('h805, 'hfe, 1, 0, 1);
    idle(1);
    irq_req = 19'(1 << 8);
    @(negedge clk);
    chk(irq_out == 0, "R6 one-cycle latency", int'(irq_out), 0);
    @(posedge clk); @(negedge clk);
    chk(irq_out == 1, "R8 source 8 at reg1 bit0", int'(irq_out), 1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk(irq_out == 1, "R7 level held", int'(irq_out), 1);
    end
    irq_req = '0;
    @(posedge clk); @(negedge clk);
    chk(irq_out == 0, "R7 drops after request", int'(irq_out), 0);

    // ignored writes leave source 8 enabled
    irq_req = 19'(1 << 8);
    drive('h805, 'hff, 0, 0, 1);
    drive('h807, 'hff, 1, 0, 1);
    drive('h803, 'hff, 1, 0, 1);
    idle(2); @(negedge clk);
    chk(irq_out == 1, "R5 stray writes ignored", int'(irq_out), 1);
    drive('h805, 'hff, 1, 0, 1);
    idle(2); @(negedge clk);
    chk(irq_out == 0, "R5 remask byte", int'(irq_out), 0);

    // cascade (register 0 bit 4) and slot 3 D pin (register 2 bit 2)
    irq_req = 19'(1 << 4);
    drive('h804, 'h00, 1, 0, 1);
    idle(2); @(negedge clk);
    chk(irq_out == 1, "R8 cascade at reg0 bit4", int'(irq_out), 1);
    drive('h804, 'h10, 1, 0, 1);
    idle(2); @(negedge clk);
    chk(irq_out == 0, "R6 masked source quiet", int'(irq_out), 0);
    drive('h806, 'h03, 1, 0, 1);
    irq_req = 19'(1 << 18);
    idle(2); @(negedge clk);
    chk(irq_out == 1, "R8 reg2 bit2 enabled", int'(irq_out), 1);
    irq_req = 19'(1 << 16);
    idle(2); @(negedge clk);
    chk(irq_out == 0, "R8 reg2 bit0 still masked", int'(irq_out), 0);

    // random phase: R3 R5 R6 R7 checked every clock by the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) irq_req = 19'($urandom);
      case (op)
        0: drive('h802 + $urandom_range(0, 6), $urandom, $urandom_range(0, 4) != 0, 0, 1);
        1: drive('h802 + $urandom_range(0, 6), 0, $urandom_range(0, 4) != 0, 1, 0);
        default: drive(0, 0, 0, 0, 0);
      endcase
    end
    idle(2);
    @(negedge clk);
    finish_run();
  end
endmodule